// File: doc/BRIEF.md
# Single-Cycle Instruction Decode Controller

This block is the control decoder for a single-cycle 32-bit load/store datapath. It is purely combinational. It reads the 6-bit primary operation field and the 6-bit function field of the current instruction. From these it drives the steering signals that the rest of the datapath uses. These signals choose the register-file write enable, the destination field, the second ALU operand, the immediate extension kind, the memory write and write-back source, the program-counter redirection kind and a 3-bit ALU operation.

The instruction subset has fourteen instructions. Four are register-register arithmetic and logic operations, three use an immediate, there is one load and one store, and there are two conditional branches, two absolute jumps and one register jump. Any encoding outside this set gives an all-zero control word. Such an instruction writes nothing and does not redirect the program counter.

Top module: `ctl_decoder`

## Requirements
- R1: Operation field 0x00 with function 0x20, 0x22, 0x24 or 0x25 (add, sub, and, or) sets rf_we=1, dst_sel=01 (rd field), opb_imm=0, imm_sx=0, and alu_op 010, 110, 000, 001 respectively. All memory and PC outputs are 0.
- R2: Operation 0x08 (add immediate) gives rf_we=1, dst_sel=00 (rt field), opb_imm=1, imm_sx=1, alu_op=010. Operation 0x0C (and immediate) is the same except imm_sx=0 and alu_op=000. Operation 0x0D (or immediate) is the same except imm_sx=0 and alu_op=001.
- R3: Operation 0x23 (load word) gives rf_we=1, dst_sel=00, opb_imm=1, imm_sx=1, wb_mem=1, alu_op=010, and mem_we=0.
- R4: Operation 0x2B (store word) gives mem_we=1, opb_imm=1, imm_sx=1, alu_op=010, rf_we=0 and wb_mem=0.
- R5: Operation 0x04 gives br_eq=1 and operation 0x05 gives br_ne=1. Both give alu_op=110 (subtract), opb_imm=0, imm_sx=1, and rf_we=0, mem_we=0.
- R6: Operation 0x02 gives jmp_abs=1 with no writes. Operation 0x03 gives jmp_abs=1, rf_we=1, link=1 and dst_sel=10 (register 31). All other outputs are 0 for both.
- R7: Operation 0x00 with function 0x08 gives jmp_reg=1. All other outputs are 0.
- R8: At most one of br_eq, br_ne, jmp_abs and jmp_reg is 1 for any input.
- R9: An operation code outside the set above, or operation 0x00 with a function code outside {0x08, 0x20, 0x22, 0x24, 0x25}, drives every output to 0.
- R10: For any operation code other than 0x00, the function field has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opc_i | input | 6 | Primary operation field of the instruction |
| fn_i | input | 6 | Function field, used when opc_i is 0x00 |
| rf_we_o | output | 1 | Register-file write enable |
| dst_sel_o | output | 2 | Destination: 00 rt, 01 rd, 10 register 31 |
| opb_imm_o | output | 1 | Second ALU operand is the extended immediate |
| mem_we_o | output | 1 | Data memory write enable |
| wb_mem_o | output | 1 | Write-back value is memory read data |
| br_eq_o | output | 1 | Branch when the ALU result is zero |
| br_ne_o | output | 1 | Branch when the ALU result is nonzero |
| jmp_abs_o | output | 1 | Jump to the absolute target field |
| jmp_reg_o | output | 1 | Jump to the address held in rs |
| link_o | output | 1 | Write the return address to the destination |
| imm_sx_o | output | 1 | 1 sign-extends the immediate, 0 zero-extends it |
| alu_op_o | output | ALU_W | ALU operation: 000 and, 001 or, 010 add, 110 sub |

## Verification
The assertions assume that both inputs hold known two-state values whenever the outputs are sampled. They also assume that the inputs settle before any consumer reads the outputs, because the decoder has no state of its own. The bench changes the inputs only on the falling edge of its clock and samples one nanosecond after the rising edge, so the outputs are always settled when read. The bench sweeps all 64 operation codes and all 64 function codes under operation 0x00. This covers every input class the decoder can see, not only the listed instructions.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

   localparam logic [5:0] OPC_RTYPE = 6'h00;
   localparam logic [5:0] OPC_JABS  = 6'h02;
   localparam logic [5:0] OPC_JLINK = 6'h03;
   localparam logic [5:0] OPC_BEQ   = 6'h04;
   localparam logic [5:0] OPC_BNE   = 6'h05;
   localparam logic [5:0] OPC_ADDI  = 6'h08;
   localparam logic [5:0] OPC_ANDI  = 6'h0C;
   localparam logic [5:0] OPC_ORI   = 6'h0D;
   localparam logic [5:0] OPC_LOAD  = 6'h23;
   localparam logic [5:0] OPC_STORE = 6'h2B;

   localparam logic [5:0] FN_JREG = 6'h08;
   localparam logic [5:0] FN_ADD  = 6'h20;
   localparam logic [5:0] FN_SUB  = 6'h22;
   localparam logic [5:0] FN_AND  = 6'h24;
   localparam logic [5:0] FN_OR   = 6'h25;

   typedef enum logic [2:0] {
      ALU_AND = 3'b000,
      ALU_OR  = 3'b001,
      ALU_ADD = 3'b010,
      ALU_SUB = 3'b110
   } alu_op_e;

   typedef enum logic [1:0] {
      DST_RT   = 2'b00,
      DST_RD   = 2'b01,
      DST_LINK = 2'b10
   } dst_e;

   typedef struct packed {
      logic    rf_we;
      dst_e    dst;
      logic    opb_imm;
      logic    mem_we;
      logic    wb_mem;
      logic    br_eq;
      logic    br_ne;
      logic    jmp_abs;
      logic    jmp_reg;
      logic    link;
      logic    imm_sx;
      alu_op_e alu;
   } ctl_t;

endpackage

// File: rtl/ctl_opc_dec.sv
module ctl_opc_dec
   import ctl_pkg::*;
#(
   parameter int OPC_W = 6
) (
   input  logic [OPC_W-1:0] opc_i,
   output ctl_t             ctl_o,
   output logic             is_rtype_o
);

   generate
      if (OPC_W != 6) begin : g_bad_opc_w
         $error("ctl_opc_dec: OPC_W must be 6");
      end
   endgenerate

   always_comb begin
      ctl_o      = '0;
      is_rtype_o = 1'b0;
      case (opc_i)
         OPC_RTYPE: is_rtype_o = 1'b1;
         OPC_JABS: begin
            ctl_o.jmp_abs = 1'b1;
         end
         OPC_JLINK: begin
            ctl_o.jmp_abs = 1'b1;
            ctl_o.rf_we   = 1'b1;
            ctl_o.link    = 1'b1;
            ctl_o.dst     = DST_LINK;
         end
         OPC_BEQ, OPC_BNE: begin
            ctl_o.br_eq  = (opc_i == OPC_BEQ);
            ctl_o.br_ne  = (opc_i == OPC_BNE);
            ctl_o.imm_sx = 1'b1;
            ctl_o.alu    = ALU_SUB;
         end
         OPC_ADDI: begin
            ctl_o.rf_we   = 1'b1;
            ctl_o.opb_imm = 1'b1;
            ctl_o.imm_sx  = 1'b1;
            ctl_o.alu     = ALU_ADD;
         end
         OPC_ANDI: begin
            ctl_o.rf_we   = 1'b1;
            ctl_o.opb_imm = 1'b1;
            ctl_o.alu     = ALU_AND;
         end
         OPC_ORI: begin
            ctl_o.rf_we   = 1'b1;
            ctl_o.opb_imm = 1'b1;
            ctl_o.alu     = ALU_OR;
         end
         OPC_LOAD: begin
            ctl_o.rf_we   = 1'b1;
            ctl_o.opb_imm = 1'b1;
            ctl_o.imm_sx  = 1'b1;
            ctl_o.wb_mem  = 1'b1;
            ctl_o.alu     = ALU_ADD;
         end
         OPC_STORE: begin
            ctl_o.mem_we  = 1'b1;
            ctl_o.opb_imm = 1'b1;
            ctl_o.imm_sx  = 1'b1;
            ctl_o.alu     = ALU_ADD;
         end
         default: ctl_o = '0;
      endcase
   end

endmodule

// File: rtl/ctl_fn_dec.sv
module ctl_fn_dec
   import ctl_pkg::*;
#(
   parameter int FN_W = 6
) (
   input  logic [FN_W-1:0] fn_i,
   output ctl_t            ctl_o
);

   generate
      if (FN_W != 6) begin : g_bad_fn_w
         $error("ctl_fn_dec: FN_W must be 6");
      end
   endgenerate

   always_comb begin
      ctl_o = '0;
      case (fn_i)
         FN_ADD, FN_SUB, FN_AND, FN_OR: begin
            ctl_o.rf_we = 1'b1;
            ctl_o.dst   = DST_RD;
            case (fn_i)
               FN_SUB:  ctl_o.alu = ALU_SUB;
               FN_AND:  ctl_o.alu = ALU_AND;
               FN_OR:   ctl_o.alu = ALU_OR;
               default: ctl_o.alu = ALU_ADD;
            endcase
         end
         FN_JREG: ctl_o.jmp_reg = 1'b1;
         default: ctl_o = '0;
      endcase
   end

endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
   import ctl_pkg::*;
#(
   parameter int OPC_W = 6,
   parameter int FN_W  = 6,
   parameter int ALU_W = 3
) (
   input  logic [OPC_W-1:0] opc_i,
   input  logic [FN_W-1:0]  fn_i,
   output logic             rf_we_o,
   output logic [1:0]       dst_sel_o,
   output logic             opb_imm_o,
   output logic             mem_we_o,
   output logic             wb_mem_o,
   output logic             br_eq_o,
   output logic             br_ne_o,
   output logic             jmp_abs_o,
   output logic             jmp_reg_o,
   output logic             link_o,
   output logic             imm_sx_o,
   output logic [ALU_W-1:0] alu_op_o
);

   localparam int ALU_PAD = ALU_W - 3;

   generate
      if (ALU_W < 3) begin : g_bad_alu_w
         $error("ctl_decoder: ALU_W must be at least 3");
      end
   endgenerate

   ctl_t opc_ctl;
   ctl_t fn_ctl;
   ctl_t sel_ctl;
   logic is_rtype;

   ctl_opc_dec #(.OPC_W(OPC_W)) u_opc (
      .opc_i      (opc_i),
      .ctl_o      (opc_ctl),
      .is_rtype_o (is_rtype)
   );

   ctl_fn_dec #(.FN_W(FN_W)) u_fn (
      .fn_i  (fn_i),
      .ctl_o (fn_ctl)
   );

   assign sel_ctl = is_rtype ? fn_ctl : opc_ctl;

   assign rf_we_o   = sel_ctl.rf_we;
   assign dst_sel_o = sel_ctl.dst;
   assign opb_imm_o = sel_ctl.opb_imm;
   assign mem_we_o  = sel_ctl.mem_we;
   assign wb_mem_o  = sel_ctl.wb_mem;
   assign br_eq_o   = sel_ctl.br_eq;
   assign br_ne_o   = sel_ctl.br_ne;
   assign jmp_abs_o = sel_ctl.jmp_abs;
   assign jmp_reg_o = sel_ctl.jmp_reg;
   assign link_o    = sel_ctl.link;
   assign imm_sx_o  = sel_ctl.imm_sx;

   generate
      if (ALU_PAD > 0) begin : g_alu_pad
         assign alu_op_o = {{ALU_PAD{1'b0}}, sel_ctl.alu};
      end else begin : g_alu_exact
         assign alu_op_o = sel_ctl.alu;
      end
   endgenerate

   always_comb begin
      AST_ONE_PC_STEER: assert ($countones({br_eq_o, br_ne_o, jmp_abs_o, jmp_reg_o}) <= 1); // R8
      if (mem_we_o)
         AST_STORE_NO_RF: assert (!rf_we_o && opb_imm_o && !wb_mem_o); // R4
      if (wb_mem_o)
         AST_LOAD_SHAPE: assert (rf_we_o && opb_imm_o && dst_sel_o == 2'b00); // R3
      if (link_o)
         AST_LINK_SHAPE: assert (rf_we_o && jmp_abs_o && dst_sel_o == 2'b10); // R6
      if (br_eq_o || br_ne_o)
         AST_BRANCH_SUB: assert (alu_op_o[2:0] == 3'b110 && !rf_we_o && !opb_imm_o); // R5
      if (dst_sel_o == 2'b01)
         AST_RD_REG_OPB: assert (!opb_imm_o && rf_we_o); // R1
      if (opc_i != '0 && opb_imm_o && rf_we_o && !imm_sx_o)
         AST_ZEXT_LOGIC: assert (alu_op_o[2:1] == 2'b00); // R2
      if (jmp_reg_o)
         AST_JREG_QUIET: assert (!rf_we_o && !mem_we_o); // R7
   end

endmodule

// File: tb/ctl_decoder_tb.sv
module ctl_decoder_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [5:0]  opc;
   logic [5:0]  fn;
   logic        rf_we, opb_imm, mem_we, wb_mem, br_eq, br_ne, jmp_abs, jmp_reg, link, imm_sx;
   logic [1:0]  dst_sel;
   logic [2:0]  alu_op;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   localparam logic [2:0] A_AND = 3'b000, A_OR = 3'b001, A_ADD = 3'b010, A_SUB = 3'b110;

   ctl_decoder dut_i (
      .opc_i(opc), .fn_i(fn), .rf_we_o(rf_we), .dst_sel_o(dst_sel),
      .opb_imm_o(opb_imm), .mem_we_o(mem_we), .wb_mem_o(wb_mem),
      .br_eq_o(br_eq), .br_ne_o(br_ne), .jmp_abs_o(jmp_abs),
      .jmp_reg_o(jmp_reg), .link_o(link), .imm_sx_o(imm_sx), .alu_op_o(alu_op)
   );

   // packed order: rf_we dst(2) opb_imm mem_we wb_mem br_eq br_ne jmp_abs jmp_reg link imm_sx alu(3)
   function automatic logic [14:0] mk(input logic rf, input logic [1:0] d, input logic oi,
                                      input logic mw, input logic wm, input logic be,
                                      input logic bn, input logic ja, input logic jr,
                                      input logic lk, input logic sx, input logic [2:0] a);
      return {rf, d, oi, mw, wm, be, bn, ja, jr, lk, sx, a};
   endfunction

   task automatic apply_chk(input string req, input logic [5:0] o, input logic [5:0] f,
                            input logic [14:0] exp);
      logic [14:0] got;
      @(negedge clk);
      opc = o;
      fn  = f;
      @(posedge clk);
      #1;
      got = {rf_we, dst_sel, opb_imm, mem_we, wb_mem, br_eq, br_ne, jmp_abs, jmp_reg,
             link, imm_sx, alu_op};
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s opc=%02h fn=%02h actual=%015b expected=%015b", req, o, f, got, exp);
      end
   endtask

   task automatic t_rtype_alu();  // R1
      apply_chk("R1", 6'h00, 6'h20, mk(1, 2'b01, 0, 0, 0, 0, 0, 0, 0, 0, 0, A_ADD));
      apply_chk("R1", 6'h00, 6'h22, mk(1, 2'b01, 0, 0, 0, 0, 0, 0, 0, 0, 0, A_SUB));
      apply_chk("R1", 6'h00, 6'h24, mk(1, 2'b01, 0, 0, 0, 0, 0, 0, 0, 0, 0, A_AND));
      apply_chk("R1", 6'h00, 6'h25, mk(1, 2'b01, 0, 0, 0, 0, 0, 0, 0, 0, 0, A_OR));
   endtask

   task automatic t_imm_alu();  // R2
      apply_chk("R2", 6'h08, 6'h00, mk(1, 2'b00, 1, 0, 0, 0, 0, 0, 0, 0, 1, A_ADD));
      apply_chk("R2", 6'h0C, 6'h00, mk(1, 2'b00, 1, 0, 0, 0, 0, 0, 0, 0, 0, A_AND));
      apply_chk("R2", 6'h0D, 6'h00, mk(1, 2'b00, 1, 0, 0, 0, 0, 0, 0, 0, 0, A_OR));
   endtask

   task automatic t_mem();  // R3 R4
      apply_chk("R3", 6'h23, 6'h00, mk(1, 2'b00, 1, 0, 1, 0, 0, 0, 0, 0, 1, A_ADD));
      apply_chk("R4", 6'h2B, 6'h00, mk(0, 2'b00, 1, 1, 0, 0, 0, 0, 0, 0, 1, A_ADD));
   endtask

   task automatic t_branch();  // R5
      apply_chk("R5", 6'h04, 6'h00, mk(0, 2'b00, 0, 0, 0, 1, 0, 0, 0, 0, 1, A_SUB));
      apply_chk("R5", 6'h05, 6'h00, mk(0, 2'b00, 0, 0, 0, 0, 1, 0, 0, 0, 1, A_SUB));
   endtask

   task automatic t_jumps();  // R6 R7
      apply_chk("R6", 6'h02, 6'h00, mk(0, 2'b00, 0, 0, 0, 0, 0, 1, 0, 0, 0, 3'b000));
      apply_chk("R6", 6'h03, 6'h00, mk(1, 2'b10, 0, 0, 0, 0, 0, 1, 0, 1, 0, 3'b000));
      apply_chk("R7", 6'h00, 6'h08, mk(0, 2'b00, 0, 0, 0, 0, 0, 0, 1, 0, 0, 3'b000));
   endtask

   function automatic bit known_opc(input logic [5:0] o);
      return o inside {6'h00, 6'h02, 6'h03, 6'h04, 6'h05, 6'h08, 6'h0C, 6'h0D, 6'h23, 6'h2B};
   endfunction

   task automatic t_unknown();  // R9 R8
      for (int i = 0; i < 64; i++)
         if (!known_opc(6'(i)))
            apply_chk("R9", 6'(i), 6'h20, 15'd0);
      for (int i = 0; i < 64; i++)
         if (!(6'(i) inside {6'h08, 6'h20, 6'h22, 6'h24, 6'h25}))
            apply_chk("R9", 6'h00, 6'(i), 15'd0);
   endtask

   task automatic t_fn_ignored();  // R10
      apply_chk("R10", 6'h08, 6'h22, mk(1, 2'b00, 1, 0, 0, 0, 0, 0, 0, 0, 1, A_ADD));
      apply_chk("R10", 6'h0D, 6'h08, mk(1, 2'b00, 1, 0, 0, 0, 0, 0, 0, 0, 0, A_OR));
      apply_chk("R10", 6'h2B, 6'h24, mk(0, 2'b00, 1, 1, 0, 0, 0, 0, 0, 0, 1, A_ADD));
      apply_chk("R10", 6'h02, 6'h08, mk(0, 2'b00, 0, 0, 0, 0, 0, 1, 0, 0, 0, 3'b000));
   endtask

   task automatic t_pc_steer_sweep();  // R8
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         opc = 6'(i);
         fn  = 6'h08;
         @(posedge clk);
         #1;
         n_chk++;
         if ($countones({br_eq, br_ne, jmp_abs, jmp_reg}) > 1) begin
            n_fail++;
            $display("FAIL R8 opc=%02h actual=%0d expected<=1", i,
                     $countones({br_eq, br_ne, jmp_abs, jmp_reg}));
         end
      end
   endtask

   initial begin
      opc = 6'h00;
      fn  = 6'h00;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // idle state after reset: operation 0x00 function 0x00 decodes to nothing (R9)
      apply_chk("R9", 6'h00, 6'h00, 15'd0);
      t_rtype_alu();
      t_imm_alu();
      t_mem();
      t_branch();
      t_jumps();
      t_fn_ignored();
      t_unknown();
      t_pc_steer_sweep();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      end
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      end
      $finish;
   end

endmodule